// File: doc/BRIEF.md
# Wide Result Serializer With Handshake

This block unloads a wide result vector, by default sixteen 32-bit products making 512 bits, through a 64-bit port. A capture strobe copies the vector into a holding buffer. A load strobe then copies the buffer into a chunk shifter, which puts the most significant 64 bits at the front. Each ready/valid handshake latches the front chunk onto the output and raises a one-cycle done pulse. A shift strobe then moves the next lower chunk to the front.

An external sequencer drives the strobes. It uses the final-chunk indication to close the sequence on the eighth handshake. A seven-shift counter pulses when the shifts for a full vector have all happened.

Top module: `wide_result_serializer`

## Requirements
- R1: After reset, `data_o`, `xfer_done_o`, `final_o` and `all_shifted_o` are all 0.
- R2: When `cap_i` is high at a clock edge, the buffer holds `y_i` from that edge onward. While `cap_i` is low, the buffer keeps its value even if `y_i` changes.
- R3: When `load_i` is high at a clock edge, the front chunk becomes bits [511:448] of the buffer, so the next handshake delivers those bits.
- R4: A handshake happens at a clock edge where `dst_valid_i` and `src_ready_i` are both high. After that edge, `data_o` holds the front chunk and `xfer_done_o` is 1 for exactly one cycle. At an edge without a handshake, `xfer_done_o` goes to 0.
- R5: `data_o` does not change at any edge without a handshake, including edges where valid is high and ready is low.
- R6: After load and k shift strobes (k from 0 to 7), the front chunk is bits [511-64k : 448-64k] of the loaded vector.
- R7: `final_o` is 1 exactly while the front chunk is the eighth chunk, that is, after seven shifts since the last load. A load clears it.
- R8: The shift counter advances only at edges where `shift_i` is high. On every seventh counted shift it wraps to zero and raises `all_shifted_o` for exactly one cycle. Load and capture do not affect the counter.
- R9: A load part-way through a transfer restarts the transfer at the top chunk of the current buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| y_i | input | 512 | Result vector to unload |
| cap_i | input | 1 | Buffer capture strobe |
| load_i | input | 1 | Copy buffer into the chunk shifter |
| shift_i | input | 1 | Advance to the next lower chunk |
| dst_valid_i | input | 1 | Valid from the sending side |
| src_ready_i | input | 1 | Ready from the receiver |
| data_o | output | 64 | Chunk latched at the last handshake |
| xfer_done_o | output | 1 | One-cycle pulse after each handshake |
| final_o | output | 1 | Eighth chunk is at the front |
| all_shifted_o | output | 1 | One-cycle pulse after each seventh shift |

## Verification
The assertions assume that the strobes come as single-cycle pulses from a sequencer. They also assume that a shift is issued only after a handshake has consumed the front chunk.

The stimulus keeps within these assumptions. It raises each strobe for one cycle, issues a shift only after a handshake, and waits through randomly drawn cycles of low ready before each handshake completes.

Because the shift counter keeps running across loads, the bench tracks its own count of shifts modulo seven. It checks the done pulse against that count and not against the chunk position.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned DEF_CHUNK_W  = 64;
  localparam int unsigned DEF_N_CHUNKS = 8;

  // Number of shift strobes that unload a full vector.
  function automatic int unsigned shifts_per_vector(input int unsigned n_chunks);
    return n_chunks - 1;
  endfunction
endpackage

// File: rtl/result_buffer.sv
module result_buffer #(
  parameter int unsigned DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] buf_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     buf_o <= '0;
    else if (cap_i) buf_o <= y_i;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (buf_o == $past(y_i)));
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(buf_o));
endmodule

// File: rtl/chunk_shifter.sv
module chunk_shifter #(
  parameter int unsigned CHUNK_W  = 64,
  parameter int unsigned N_CHUNKS = 8,
  localparam int unsigned DATA_W  = CHUNK_W * N_CHUNKS,
  localparam int unsigned IDX_W   = $clog2(N_CHUNKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [DATA_W-1:0]  buf_i,
  output logic [CHUNK_W-1:0] front_o,
  output logic               final_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CHUNKS - 1);

  logic [DATA_W-1:0] sreg_q;
  logic [IDX_W-1:0]  idx_q;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return (i == LAST) ? i : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      sreg_q <= buf_i;
      idx_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[DATA_W-CHUNK_W-1:0], {CHUNK_W{1'b0}}};
      idx_q  <= next_idx(idx_q);
    end
  end

  assign front_o = sreg_q[DATA_W-1 -: CHUNK_W];
  assign final_o = (idx_q == LAST);

  p_load_front_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (front_o == $past(buf_i[DATA_W-1 -: CHUNK_W])));
  p_load_clears_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !final_o);
  p_shift_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (front_o == $past(sreg_q[DATA_W-CHUNK_W-1 -: CHUNK_W])));
endmodule

// File: rtl/rv_out_stage.sv
module rv_out_stage #(
  parameter int unsigned CHUNK_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               ready_i,
  input  logic [CHUNK_W-1:0] front_i,
  output logic [CHUNK_W-1:0] data_o,
  output logic               done_o
);
  logic hs;
  assign hs = valid_i && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= hs;
      if (hs) data_o <= front_i;
    end
  end

  p_done_after_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (done_o && data_o == $past(front_i)));
  p_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> !done_o);
  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ready_i) |=> $stable(data_o));
endmodule

// File: rtl/shift_counter.sv
module shift_counter #(
  parameter int unsigned LIMIT = 7,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT - 1);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = en_i && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= wrap;
      if (wrap)      cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == '0));
endmodule

// File: rtl/wide_result_serializer.sv
module wide_result_serializer #(
  parameter int unsigned CHUNK_W  = ser_pkg::DEF_CHUNK_W,
  parameter int unsigned N_CHUNKS = ser_pkg::DEF_N_CHUNKS,
  localparam int unsigned DATA_W  = CHUNK_W * N_CHUNKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  y_i,
  input  logic               cap_i,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic               dst_valid_i,
  input  logic               src_ready_i,
  output logic [CHUNK_W-1:0] data_o,
  output logic               xfer_done_o,
  output logic               final_o,
  output logic               all_shifted_o
);
  logic [DATA_W-1:0]  buf_w;
  logic [CHUNK_W-1:0] front_w;

  result_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .y_i(y_i), .buf_o(buf_w));

  chunk_shifter #(.CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS)) u_shf (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .shift_i(shift_i),
    .buf_i(buf_w), .front_o(front_w), .final_o(final_o));

  rv_out_stage #(.CHUNK_W(CHUNK_W)) u_rv (
    .clk(clk), .rst_n(rst_n), .valid_i(dst_valid_i), .ready_i(src_ready_i),
    .front_i(front_w), .data_o(data_o), .done_o(xfer_done_o));

  shift_counter #(.LIMIT(ser_pkg::shifts_per_vector(N_CHUNKS))) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(shift_i), .done_o(all_shifted_o));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!xfer_done_o && !all_shifted_o && !final_o && data_o == '0));
endmodule

// File: tb/wide_result_serializer_tb.sv
module wide_result_serializer_tb;
  localparam int CW = 64;
  localparam int NC = 8;
  localparam int DW = CW * NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] y_i = '0;
  logic cap_i = 0, load_i = 0, shift_i = 0, dst_valid_i = 0, src_ready_i = 0;
  logic [CW-1:0] data_o;
  logic xfer_done_o, final_o, all_shifted_o;

  int checks = 0;
  int errors = 0;
  int shift_model = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wide_result_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .y_i(y_i), .cap_i(cap_i), .load_i(load_i),
    .shift_i(shift_i), .dst_valid_i(dst_valid_i), .src_ready_i(src_ready_i),
    .data_o(data_o), .xfer_done_o(xfer_done_o), .final_o(final_o),
    .all_shifted_o(all_shifted_o));

  function automatic logic [CW-1:0] exp_chunk(input logic [DW-1:0] v, input int k);
    logic [DW-1:0] s;
    s = v >> (CW * (NC - 1 - k));
    return s[CW-1:0];
  endfunction

  function automatic logic [DW-1:0] rand_vec();
    logic [DW-1:0] v;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic capture(input logic [DW-1:0] v);
    @(negedge clk); y_i = v; cap_i = 1; tick(); cap_i = 0;
  endtask

  task automatic do_load();
    @(negedge clk); load_i = 1; tick(); load_i = 0;
    check(final_o == 1'b0, "R7 final low after load", CW'(final_o), '0);
  endtask

  task automatic do_shift(input bool_dummy);
    @(negedge clk); shift_i = 1; tick(); shift_i = 0;
    shift_model++;
    if (shift_model == NC - 1) begin
      shift_model = 0;
      check(all_shifted_o == 1'b1, "R8 pulse on seventh shift", CW'(all_shifted_o), 1);
    end else
      check(all_shifted_o == 1'b0, "R8 no pulse", CW'(all_shifted_o), 0);
  endtask

  // One handshake with random backpressure; expects chunk exp.
  task automatic handshake(input logic [CW-1:0] exp, input int bp_pct);
    logic [CW-1:0] prev;
    bit got;
    got = 0;
    while (!got) begin
      @(negedge clk);
      prev = data_o;
      dst_valid_i = 1;
      src_ready_i = (($urandom % 100) >= bp_pct);
      got = src_ready_i;
      tick();
      if (got) begin
        check(data_o == exp, "R4/R6 chunk value", data_o, exp);
        check(xfer_done_o == 1'b1, "R4 done pulse", CW'(xfer_done_o), 1);
      end else begin
        check(data_o == prev, "R5 hold under backpressure", data_o, prev);
        check(xfer_done_o == 1'b0, "R4 no done without ready", CW'(xfer_done_o), 0);
      end
    end
    @(negedge clk); dst_valid_i = 0; src_ready_i = 0;
    tick();
    check(xfer_done_o == 1'b0, "R4 done is one cycle", CW'(xfer_done_o), 0);
    check(data_o == exp, "R5 hold while idle", data_o, exp);
  endtask

  task automatic full_transfer(input logic [DW-1:0] v, input int bp_pct);
    for (int k = 0; k < NC; k++) begin
      check(final_o == (k == NC - 1), "R7 final indication", CW'(final_o), CW'(k == NC - 1));
      handshake(exp_chunk(v, k), bp_pct);
      if (k < NC - 1) do_shift(1'b0);
    end
    tick();
    check(all_shifted_o == 1'b0, "R8 pulse ended", CW'(all_shifted_o), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a, b;
    void'($urandom(32'd1234));
    tick(); tick();
    check(data_o == '0, "R1 data reset", data_o, '0);
    check({xfer_done_o, final_o, all_shifted_o} == 3'b000, "R1 flags reset",
          CW'({xfer_done_o, final_o, all_shifted_o}), '0);
    @(negedge clk); rst_n = 1;

    // Directed: counting pattern, no backpressure
    for (int i = 0; i < NC; i++) a[DW-1-i*CW -: CW] = {32'hC0DE0000 + i, 32'h1000 + i};
    capture(a);
    do_load();
    full_transfer(a, 0);

    // R2: buffer not changed by y_i without capture
    b = rand_vec();
    @(negedge clk); y_i = b; tick(); tick();
    do_load();
    check(final_o == 1'b0, "R2 reload", CW'(final_o), 0);
    handshake(exp_chunk(a, 0), 0);
    check(data_o == a[DW-1 -: CW], "R2 buffer kept old value", data_o, a[DW-1 -: CW]);

    // R9: load part-way restarts at the top chunk
    do_shift(1'b0);
    handshake(exp_chunk(a, 1), 30);
    do_shift(1'b0);
    capture(b);
    do_load();
    full_transfer(b, 40);

    // R3/R6 random vectors with backpressure
    for (int t = 0; t < 6; t++) begin
      a = rand_vec();
      capture(a);
      do_load();
      full_transfer(a, 60);
    end

    // R8: idle cycles with no shift do not move the counter
    repeat (5) begin
      tick();
      check(all_shifted_o == 1'b0, "R8 hold without shift", CW'(all_shifted_o), 0);
    end
    a = rand_vec();
    capture(a);
    do_load();
    full_transfer(a, 20);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule